// File: doc/BRIEF.md
# Buffered Byte-Access Timer

A 16-bit up-counting timer that an 8-bit host reaches one byte at a time through four register addresses. Pulses on a count-enable input pass through a selectable divider (1, 2, 4 or 8). The counter advances once per divider terminal count while the run bit is set. A rollover from all ones to zero sets a sticky overflow flag. Software clears the flag by writing a one to it.

A mode bit in the control register makes 16-bit access atomic. In buffered mode the high-byte address reaches a holding register, not the counter. A strobed read of the low byte copies the counter's high byte into that holding register, so the value read next from the high byte belongs to the same instant as the low byte. A write to the low byte loads the counter's high half from the holding register and its low half from the bus, both in one clock. With the mode bit clear, the host reads and writes both counter bytes directly, and the holding register is left alone.

Top module: `tmr_buffered_timer`

## Requirements
- R1: After reset the counter, holding register, divider, control register and overflow flag are all zero, so every register address reads 0x00 and `ovf` is low.
- R2: The control register sits at address 2. Bit 0 is run, bits 2:1 are the divider select s, and bit 3 is buffered mode; it reads back in bits 3:0 with zeros above. While run is set, the counter advances once every 2^s cycles in which `cnt_en` is high. While run is clear, it does not advance.
- R3: In buffered mode a read of address 0 with `rd_en` high copies the counter's high byte into the holding register. A later read of address 1 returns that copy, even if the counter has moved on since.
- R4: In buffered mode a write to address 1 changes only the holding register and leaves the counter as it was.
- R5: In buffered mode a write to address 0 loads the counter's high byte from the holding register and its low byte from `wdata`, both at the same clock edge.
- R6: A write to address 0 clears the divider's partial count. A write to address 1 does not.
- R7: With bit 3 clear, address 1 reads and writes the counter's high byte directly. A write to address 0 changes only the low byte. Low-byte reads never alter the holding register.
- R8: A counter rollover from 0xFFFF to 0x0000 sets `ovf`. The flag reads at bit 0 of address 3 and stays set until a write to address 3 with bit 0 set. Writing a zero there has no effect.
- R9: When a host write to a counter byte falls in the same cycle as an increment, the written value is kept and the increment is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address (0 low, 1 high, 2 control, 3 status) |
| wr_en | input | 1 | Write strobe for the addressed register |
| rd_en | input | 1 | Read strobe; gives a low-byte read its snapshot side effect |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| cnt_en | input | 1 | Count-enable pulses into the divider |
| ovf | output | 1 | Sticky overflow flag |

## Verification
A stale or wrongly captured holding register shows up on the first high-byte read after a strobed low-byte read. The bench forces this case by letting the counter carry between the two reads. A missed or extra divider clear, or an increment that slips past a write, changes the counter value. That error is visible at the next 16-bit read, a few cycles after a chosen number of pulses. Holding-register writes that leak into the counter are caught by switching to direct mode and reading the high byte straight away.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BYTE_W   = 8;
    localparam int DIV_SEL_W = 2;

    typedef enum logic [1:0] {
        REG_LO   = 2'd0,
        REG_HI   = 2'd1,
        REG_CTRL = 2'd2,
        REG_STAT = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic                 buffered;
        logic [DIV_SEL_W-1:0] div_sel;
        logic                 run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int SEL_W = tmr_pkg::DIV_SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             run,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PS_W = (1 << SEL_W) - 1;

    logic [PS_W-1:0] pcnt;
    logic [PS_W-1:0] limit;

    always_comb begin
        limit = PS_W'((1 << sel) - 1);
        tick  = en && run && !clr && (pcnt == limit);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pcnt <= '0;
        end else if (en && run) begin
            pcnt <= tick ? '0 : pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int DATA_W = tmr_pkg::BYTE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                ld_lo,
    input  logic                ld_hi,
    input  logic [DATA_W-1:0]   lo_val,
    input  logic [DATA_W-1:0]   hi_val,
    output logic [2*DATA_W-1:0] count,
    output logic                wrap
);
    localparam int CNT_W = 2 * DATA_W;

    logic any_ld;

    always_comb begin
        any_ld = ld_lo || ld_hi;
        wrap   = tick && !any_ld && (&count);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (any_ld) begin
            if (ld_hi) count[CNT_W-1:DATA_W] <= hi_val;
            if (ld_lo) count[DATA_W-1:0]     <= lo_val;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_host_regs.sv
module tmr_host_regs
    import tmr_pkg::*;
#(
    parameter int DATA_W = tmr_pkg::BYTE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          addr,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic [2*DATA_W-1:0] count,
    input  logic                wrap,
    output ctrl_t               ctrl,
    output logic [DATA_W-1:0]   hbuf,
    output logic                ld_lo,
    output logic                ld_hi,
    output logic [DATA_W-1:0]   lo_val,
    output logic [DATA_W-1:0]   hi_val,
    output logic                ps_clr,
    output logic                ovf
);
    localparam int CNT_W = 2 * DATA_W;

    logic lo_wr, hi_wr, ctrl_wr, stat_wr, lo_rd;

    always_comb begin
        lo_wr   = wr_en && (addr == REG_LO);
        hi_wr   = wr_en && (addr == REG_HI);
        ctrl_wr = wr_en && (addr == REG_CTRL);
        stat_wr = wr_en && (addr == REG_STAT);
        lo_rd   = rd_en && (addr == REG_LO);

        ld_lo   = lo_wr;
        ld_hi   = ctrl.buffered ? lo_wr : hi_wr;
        lo_val  = wdata;
        hi_val  = ctrl.buffered ? hbuf : wdata;
        ps_clr  = lo_wr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hbuf <= '0;
        end else if (ctrl.buffered) begin
            if (hi_wr)      hbuf <= wdata;
            else if (lo_rd) hbuf <= count[CNT_W-1:DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf <= 1'b0;
        end else if (wrap) begin
            ovf <= 1'b1;
        end else if (stat_wr && wdata[0]) begin
            ovf <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr_e'(addr))
            REG_LO:   rdata = count[DATA_W-1:0];
            REG_HI:   rdata = ctrl.buffered ? hbuf : count[CNT_W-1:DATA_W];
            REG_CTRL: rdata = DATA_W'(ctrl);
            REG_STAT: rdata = DATA_W'(ovf);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_buffered_timer.sv
module tmr_buffered_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W = tmr_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              cnt_en,
    output logic              ovf
);
    localparam int CNT_W = 2 * DATA_W;

    ctrl_t              ctrl_q;
    logic [DATA_W-1:0]  hbuf_q;
    logic [CNT_W-1:0]   count_q;
    logic               tick, wrap;
    logic               ld_lo, ld_hi, ps_clr;
    logic [DATA_W-1:0]  lo_val, hi_val;

    tmr_host_regs #(.DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (addr),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wdata  (wdata),
        .rdata  (rdata),
        .count  (count_q),
        .wrap   (wrap),
        .ctrl   (ctrl_q),
        .hbuf   (hbuf_q),
        .ld_lo  (ld_lo),
        .ld_hi  (ld_hi),
        .lo_val (lo_val),
        .hi_val (hi_val),
        .ps_clr (ps_clr),
        .ovf    (ovf)
    );

    tmr_prescaler #(.SEL_W(DIV_SEL_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .en   (cnt_en),
        .run  (ctrl_q.run),
        .clr  (ps_clr),
        .sel  (ctrl_q.div_sel),
        .tick (tick)
    );

    tmr_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .ld_lo  (ld_lo),
        .ld_hi  (ld_hi),
        .lo_val (lo_val),
        .hi_val (hi_val),
        .count  (count_q),
        .wrap   (wrap)
    );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int DATA_W = tmr_pkg::BYTE_W
) (
    input logic                clk,
    input logic                rst,
    input logic [1:0]          addr,
    input logic                wr_en,
    input logic                rd_en,
    input logic [DATA_W-1:0]   wdata,
    input logic                ovf,
    input logic [2*DATA_W-1:0] count,
    input logic [DATA_W-1:0]   hbuf,
    input logic                buffered
);
    localparam int CNT_W = 2 * DATA_W;

    // R3
    snapshot_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (buffered && rd_en && !wr_en && addr == REG_LO)
        |=> hbuf == $past(count[CNT_W-1:DATA_W]));

    // R4
    hibuf_isolated_chk: assert property (@(posedge clk) disable iff (rst)
        (buffered && wr_en && addr == REG_HI)
        |=> (count == $past(count)) || (count == $past(count) + 1'b1));

    // R5
    atomic_load_chk: assert property (@(posedge clk) disable iff (rst)
        (buffered && wr_en && addr == REG_LO)
        |=> count[CNT_W-1:DATA_W] == $past(hbuf));

    // R7
    direct_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!buffered && wr_en && addr == REG_HI)
        |=> count[CNT_W-1:DATA_W] == $past(wdata));

    // R8
    sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && !(wr_en && addr == REG_STAT && wdata[0])) |=> ovf);

    // R9
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == REG_LO) |=> count[DATA_W-1:0] == $past(wdata));
endmodule

bind tmr_buffered_timer tmr_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .ovf      (ovf),
    .count    (count_q),
    .hbuf     (hbuf_q),
    .buffered (ctrl_q.buffered)
);

// File: tb/tmr_buffered_timer_test.sv
module tmr_buffered_timer_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       cnt_en = 1'b0;
    logic       ovf;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // ctrl: bit3 buffered, bits2:1 divider select, bit0 run
    localparam logic [1:0] A_LO = 2'd0, A_HI = 2'd1, A_CTRL = 2'd2, A_STAT = 2'd3;

    tmr_buffered_timer uut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .cnt_en(cnt_en), .ovf(ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int got, input int exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input bit strobe, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = strobe;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input int n);
        @(negedge clk);
        cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic load16(input logic [15:0] v);
        wr(A_HI, v[15:8]);
        wr(A_LO, v[7:0]);
    endtask

    task automatic read16(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(A_LO, 1'b1, lo);
        rd(A_HI, 1'b0, hi);
        v = {hi, lo};
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], 1'b0, v);
            check("R1 reg read", v, 0);
        end
        check("R1 ovf", ovf, 0);
    endtask

    task automatic t_prescale();
        logic [15:0] c;
        logic [7:0] v;
        wr(A_CTRL, 8'h0D);
        rd(A_CTRL, 1'b0, v);
        check("R2 ctrl readback", v, 8'h0D);
        load16(16'h0000);
        pulse(8);
        read16(c);
        check("R2 div4", c, 2);
        wr(A_CTRL, 8'h09);
        load16(16'h0000);
        pulse(5);
        read16(c);
        check("R2 div1", c, 5);
        wr(A_CTRL, 8'h0F);
        load16(16'h0000);
        pulse(8);
        read16(c);
        check("R2 div8", c, 1);
        wr(A_CTRL, 8'h08);
        pulse(4);
        read16(c);
        check("R2 run off", c, 1);
    endtask

    task automatic t_snapshot();
        logic [7:0] v;
        wr(A_CTRL, 8'h09);
        load16(16'h00FF);
        rd(A_LO, 1'b1, v);
        check("R3 low", v, 8'hFF);
        pulse(1);
        rd(A_HI, 1'b0, v);
        check("R3 snapshot kept across carry", v, 8'h00);
        rd(A_LO, 1'b1, v);
        check("R3 low after carry", v, 8'h00);
        rd(A_HI, 1'b0, v);
        check("R3 fresh snapshot", v, 8'h01);
    endtask

    task automatic t_hibuf();
        logic [7:0] v;
        wr(A_CTRL, 8'h08);
        load16(16'h1234);
        wr(A_HI, 8'hAB);
        rd(A_HI, 1'b0, v);
        check("R4 buffer holds write", v, 8'hAB);
        wr(A_CTRL, 8'h00);
        rd(A_HI, 1'b0, v);
        check("R4 counter high untouched", v, 8'h12);
        rd(A_LO, 1'b0, v);
        check("R4 counter low untouched", v, 8'h34);
    endtask

    task automatic t_atomic();
        logic [7:0] v;
        wr(A_CTRL, 8'h08);
        load16(16'h0000);
        wr(A_HI, 8'h5A);
        wr(A_CTRL, 8'h00);
        rd(A_HI, 1'b0, v);
        check("R5 high waits for low write", v, 8'h00);
        wr(A_CTRL, 8'h08);
        wr(A_LO, 8'hC3);
        wr(A_CTRL, 8'h00);
        rd(A_HI, 1'b0, v);
        check("R5 high loaded", v, 8'h5A);
        rd(A_LO, 1'b0, v);
        check("R5 low loaded", v, 8'hC3);
    endtask

    task automatic t_psclr();
        logic [15:0] c;
        wr(A_CTRL, 8'h0F);
        load16(16'h0000);
        pulse(5);
        wr(A_HI, 8'h00);
        pulse(3);
        read16(c);
        check("R6 high write keeps divider", c, 1);
        pulse(5);
        wr(A_LO, 8'h00);
        pulse(3);
        read16(c);
        check("R6 low write clears divider", c, 0);
        pulse(5);
        read16(c);
        check("R6 divider from zero", c, 1);
    endtask

    task automatic t_legacy();
        logic [7:0] v;
        wr(A_CTRL, 8'h08);
        wr(A_HI, 8'h3C);
        wr(A_CTRL, 8'h01);
        wr(A_HI, 8'h77);
        rd(A_HI, 1'b0, v);
        check("R7 direct high write", v, 8'h77);
        wr(A_LO, 8'h10);
        rd(A_LO, 1'b1, v);
        check("R7 low write", v, 8'h10);
        rd(A_HI, 1'b0, v);
        check("R7 low write keeps high", v, 8'h77);
        pulse(1);
        rd(A_LO, 1'b1, v);
        check("R7 counts", v, 8'h11);
        wr(A_CTRL, 8'h08);
        rd(A_HI, 1'b0, v);
        check("R7 buffer untouched", v, 8'h3C);
    endtask

    task automatic t_ovf();
        logic [15:0] c;
        logic [7:0] v;
        wr(A_CTRL, 8'h09);
        load16(16'hFFFE);
        pulse(1);
        check("R8 no early flag", ovf, 0);
        pulse(1);
        check("R8 flag on rollover", ovf, 1);
        read16(c);
        check("R8 counter wrapped", c, 0);
        pulse(2);
        check("R8 sticky", ovf, 1);
        rd(A_STAT, 1'b0, v);
        check("R8 status bit", v, 8'h01);
        wr(A_STAT, 8'h00);
        check("R8 zero write ignored", ovf, 1);
        wr(A_STAT, 8'h01);
        check("R8 one clears", ovf, 0);
        rd(A_STAT, 1'b0, v);
        check("R8 status cleared", v, 8'h00);
    endtask

    task automatic t_collide();
        logic [15:0] c;
        logic [7:0] v;
        wr(A_CTRL, 8'h09);
        wr(A_HI, 8'h12);
        @(negedge clk);
        addr = A_LO; wdata = 8'h34; wr_en = 1'b1; cnt_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; cnt_en = 1'b0;
        read16(c);
        check("R9 low write beats increment", c, 16'h1234);
        wr(A_CTRL, 8'h01);
        wr(A_LO, 8'h00);
        wr(A_HI, 8'h00);
        @(negedge clk);
        addr = A_HI; wdata = 8'h40; wr_en = 1'b1; cnt_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; cnt_en = 1'b0;
        rd(A_HI, 1'b0, v);
        check("R9 high write value", v, 8'h40);
        rd(A_LO, 1'b0, v);
        check("R9 increment discarded", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_prescale();
        t_snapshot();
        t_hibuf();
        t_atomic();
        t_psclr();
        t_legacy();
        t_ovf();
        t_collide();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule